// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker turns an in-memory command block and a linked run of region descriptors into a stream of transfer segments for a data mover. A pulse on `eng_go` starts it. It reads a three-word header from the command block at `cb_base`, checks the control byte, and then reads 8-byte descriptors one after another, starting at the pointer held in the header. Each descriptor with a non-zero length is offered to the data mover on a valid/ready segment port. The walk ends at the descriptor that carries the end-of-chain flag.

While the walk runs, the walker sums the segment lengths. At the end it compares the sum with the total transfer length from the header and builds a response byte. It writes that byte back into byte 0 of the command block, then raises `done`, and raises `error` too if the response carries its error summary bit. The memory port is 32 bits wide with a fixed read latency: data requested in one cycle is on `mem_rdata` in the next. A halt input abandons a walk without a write-back. An engine reset input returns the walker to idle and clears all status.

Top module: `sg_chain_walker`

## Requirements
- R1: A go pulse in idle reads the words at `cb_base`, `cb_base+4` and `cb_base+8` in that order. Bits 31:24 of the first word are the control byte (byte 3). The second word is the total length. The third word is the first descriptor address.
- R2: If control bit 0 (valid) is clear, no descriptor is read and no segment is issued. The response is 0x84 (ignored bit 2 plus error summary bit 7) and `error` is set.
- R3: If the block is valid and control bit 2 (has-data) is clear, no descriptor is read and the response is 0x01 (complete bit 0).
- R4: A descriptor is two words. Word 0 is the segment address. In word 1, bits 15:0 are the length and bits 31:24 are the flags. Each descriptor is presented as one segment, and its address, length and flags stay stable until `seg_ready` is seen.
- R5: A descriptor whose flag bit 7 (end) is set ends the chain. Otherwise the next descriptor is read 8 bytes further on.
- R6: When the summed lengths equal the total, the response is 0x01 and `error` stays low.
- R7: When the summed lengths are below the total, the response is 0xA1 (complete, underflow bit 5, summary bit 7) and `error` is set.
- R8: When the summed lengths exceed the total, the response is 0xC1 (complete, overflow bit 6, summary bit 7) and `error` is set. If the last descriptor has flag bit 1 (drain), overflow is not flagged and the response is 0x01.
- R9: A descriptor with a zero length field is never issued as a segment. It ends the walk with response 0x80 and `error` set.
- R10: The response is written as one word write to `cb_base` with strobe 0001 and the byte in `mem_wdata[7:0]`. `done` rises in the cycle after the write.
- R11: If control bit 3 (interrupt enable) is set, `cmpl_evt` pulses for one cycle as `done` rises. If the bit is clear, `cmpl_evt` does not pulse.
- R12: `eng_halt` during a walk, before the response write, returns the walker to idle with `stopped` high, `done` low and no write-back.
- R13: `eng_reset` returns the walker to idle in the next cycle and clears `done`, `error` and `stopped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_go | input | 1 | Start a walk (accepted only in idle) |
| eng_reset | input | 1 | Synchronous engine reset |
| eng_halt | input | 1 | Abandon the current walk |
| cb_base | input | ADDR_W | Byte address of the command block |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | 32 | Segment address |
| seg_len | output | LEN_W | Segment length in bytes |
| seg_flags | output | 8 | Descriptor flags byte |
| done | output | 1 | Walk finished and response written |
| error | output | 1 | Finished response carries the error summary |
| stopped | output | 1 | Walk was halted |
| cmpl_evt | output | 1 | One-cycle completion event |

## Verification
The main function is driven by a table of command blocks. Two descriptors that sum exactly to the total, that fall short of it, and that exceed it separate the three length outcomes. The same excess case is repeated with drain set on the last descriptor, which shows that drain suppresses only the overflow flag. Invalid and no-data blocks show that the walker returns without reading descriptors. A zero-length second descriptor and a single maximal 65535-byte descriptor probe both edges of the length field. Directed runs stall the segment port to check that segments are held, halt and reset a walk in flight, and check the write-then-done ordering and the interrupt-enable event.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CB_RD,
      ST_CB_CAP,
      ST_DS_RD,
      ST_DS_CAP,
      ST_SEG,
      ST_JUDGE,
      ST_RESP
   } sgw_state_e;

   // control byte bit positions
   localparam int CTL_VALID = 0;
   localparam int CTL_DATA  = 2;
   localparam int CTL_IEN   = 3;

   // descriptor flag bit positions
   localparam int DF_DRAIN  = 1;
   localparam int DF_END    = 7;

   // response byte bit positions
   localparam int RF_DONE   = 0;
   localparam int RF_IGN    = 2;
   localparam int RF_UNDER  = 5;
   localparam int RF_OVER   = 6;
   localparam int RF_ERR    = 7;

   localparam int DESC_BYTES = 8;

endpackage

// File: rtl/sgw_accum.sv
module sgw_accum #(
   parameter int LEN_W = 16,
   parameter int SUM_W = 33
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_val,
   output logic [SUM_W-1:0] sum
);

   if (SUM_W <= LEN_W) begin : g_bad_width
      initial $error("sgw_accum: SUM_W must exceed LEN_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (clr) begin
         sum <= '0;
      end else if (add_en) begin
         sum <= sum + SUM_W'(add_val);
      end
   end

   // R6
   acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> sum >= $past(sum));

endmodule

// File: rtl/sgw_len_judge.sv
module sgw_len_judge #(
   parameter int SUM_W       = 33,
   parameter int TOT_W       = 32,
   parameter bit HONOR_DRAIN = 1'b1
) (
   input  logic [SUM_W-1:0] sum,
   input  logic [TOT_W-1:0] total,
   input  logic             drain,
   output logic             short_o,
   output logic             excess_o
);

   if (SUM_W <= TOT_W) begin : g_bad_width
      initial $error("sgw_len_judge: SUM_W must exceed TOT_W");
   end

   logic over_raw;

   assign short_o  = sum < SUM_W'(total);
   assign over_raw = sum > SUM_W'(total);

   if (HONOR_DRAIN) begin : g_drain
      assign excess_o = over_raw & ~drain;
   end else begin : g_nodrain
      assign excess_o = over_raw;
   end

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int TOT_W       = 32,
   parameter bit HONOR_DRAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_go,
   input  logic              eng_reset,
   input  logic              eng_halt,
   input  logic [ADDR_W-1:0] cb_base,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_wstrb,
   input  logic [31:0]       mem_rdata,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [31:0]       seg_addr,
   output logic [LEN_W-1:0]  seg_len,
   output logic [7:0]        seg_flags,
   output logic              done,
   output logic              error,
   output logic              stopped,
   output logic              cmpl_evt
);

   localparam int SUM_W = TOT_W + 1;

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      initial $error("sg_chain_walker: ADDR_W must be 8..32");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      initial $error("sg_chain_walker: LEN_W must be 1..16");
   end
   if (TOT_W < LEN_W || TOT_W > 32) begin : g_bad_tot
      initial $error("sg_chain_walker: TOT_W must be LEN_W..32");
   end

   sgw_state_e       st;
   logic [1:0]       wd;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [TOT_W-1:0] total_q;
   logic             ctl_ien_q;
   logic             ctl_data_q;
   logic [7:0]       resp_q;
   logic [31:0]      seg_addr_q;
   logic [LEN_W-1:0] seg_len_q;
   logic [7:0]       seg_flags_q;

   logic             halt_now;
   logic             acc_clr;
   logic             acc_add;
   logic [SUM_W-1:0] acc_sum;
   logic             len_short;
   logic             len_excess;

   assign halt_now = eng_halt && (st != ST_IDLE) && (st != ST_RESP);
   assign acc_clr  = (st == ST_IDLE) && eng_go;
   assign acc_add  = (st == ST_SEG) && seg_ready;

   sgw_accum #(.LEN_W(LEN_W), .SUM_W(SUM_W)) i_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr),
      .add_en  (acc_add),
      .add_val (seg_len_q),
      .sum     (acc_sum)
   );

   sgw_len_judge #(.SUM_W(SUM_W), .TOT_W(TOT_W), .HONOR_DRAIN(HONOR_DRAIN)) i_judge (
      .sum      (acc_sum),
      .total    (total_q),
      .drain    (seg_flags_q[DF_DRAIN]),
      .short_o  (len_short),
      .excess_o (len_excess)
   );

   always_comb begin
      mem_rd    = (st == ST_CB_RD) || (st == ST_DS_RD);
      mem_wr    = (st == ST_RESP);
      mem_wdata = {24'd0, resp_q};
      mem_wstrb = 4'b0001;
      seg_valid = (st == ST_SEG);
      seg_addr  = seg_addr_q;
      seg_len   = seg_len_q;
      seg_flags = seg_flags_q;
      case (st)
         ST_CB_RD: mem_addr = base_q + ADDR_W'({wd, 2'b00});
         ST_DS_RD: mem_addr = ptr_q + ADDR_W'({wd, 2'b00});
         default:  mem_addr = base_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         wd          <= '0;
         base_q      <= '0;
         ptr_q       <= '0;
         total_q     <= '0;
         ctl_ien_q   <= 1'b0;
         ctl_data_q  <= 1'b0;
         resp_q      <= '0;
         seg_addr_q  <= '0;
         seg_len_q   <= '0;
         seg_flags_q <= '0;
         done        <= 1'b0;
         error       <= 1'b0;
         stopped     <= 1'b0;
         cmpl_evt    <= 1'b0;
      end else begin
         cmpl_evt <= 1'b0;
         if (eng_reset) begin
            st      <= ST_IDLE;
            done    <= 1'b0;
            error   <= 1'b0;
            stopped <= 1'b0;
         end else if (halt_now) begin
            st      <= ST_IDLE;
            done    <= 1'b0;
            error   <= 1'b0;
            stopped <= 1'b1;
         end else begin
            case (st)
               ST_IDLE: if (eng_go) begin
                  base_q  <= cb_base;
                  wd      <= 2'd0;
                  done    <= 1'b0;
                  error   <= 1'b0;
                  stopped <= 1'b0;
                  st      <= ST_CB_RD;
               end
               ST_CB_RD: st <= ST_CB_CAP;
               ST_CB_CAP: begin
                  case (wd)
                     2'd0: begin
                        ctl_ien_q  <= mem_rdata[24 + CTL_IEN];
                        ctl_data_q <= mem_rdata[24 + CTL_DATA];
                        if (!mem_rdata[24 + CTL_VALID]) begin
                           resp_q <= 8'((1 << RF_IGN) | (1 << RF_ERR));
                           st     <= ST_RESP;
                        end else begin
                           wd <= 2'd1;
                           st <= ST_CB_RD;
                        end
                     end
                     2'd1: begin
                        total_q <= mem_rdata[TOT_W-1:0];
                        wd      <= 2'd2;
                        st      <= ST_CB_RD;
                     end
                     default: begin
                        ptr_q <= mem_rdata[ADDR_W-1:0];
                        wd    <= 2'd0;
                        if (!ctl_data_q) begin
                           resp_q <= 8'(1 << RF_DONE);
                           st     <= ST_RESP;
                        end else begin
                           st <= ST_DS_RD;
                        end
                     end
                  endcase
               end
               ST_DS_RD: st <= ST_DS_CAP;
               ST_DS_CAP: begin
                  if (wd == 2'd0) begin
                     seg_addr_q <= mem_rdata;
                     wd         <= 2'd1;
                     st         <= ST_DS_RD;
                  end else begin
                     seg_len_q   <= mem_rdata[LEN_W-1:0];
                     seg_flags_q <= mem_rdata[31:24];
                     wd          <= 2'd0;
                     if (mem_rdata[15:0] == 16'd0) begin
                        resp_q <= 8'(1 << RF_ERR);
                        st     <= ST_RESP;
                     end else begin
                        st <= ST_SEG;
                     end
                  end
               end
               ST_SEG: if (seg_ready) begin
                  if (seg_flags_q[DF_END]) begin
                     st <= ST_JUDGE;
                  end else begin
                     ptr_q <= ptr_q + ADDR_W'(DESC_BYTES);
                     st    <= ST_DS_RD;
                  end
               end
               ST_JUDGE: begin
                  resp_q <= {len_short | len_excess, len_excess, len_short, 4'd0, 1'b1};
                  st     <= ST_RESP;
               end
               ST_RESP: begin
                  st       <= ST_IDLE;
                  done     <= 1'b1;
                  error    <= resp_q[RF_ERR];
                  cmpl_evt <= ctl_ien_q;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R4
   seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !seg_ready && !eng_reset && !eng_halt
      |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_flags));

   // R9
   seg_len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> seg_len != '0);

   // R10
   wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && !eng_reset |=> done && !mem_wr);

   // R11
   evt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_evt |-> done && $rose(done));

   // R12
   halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_halt && seg_valid && !eng_reset |=> stopped && !done && !seg_valid);

   // R13
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_reset |=> !done && !stopped && !error && !seg_valid && !mem_rd && !mem_wr);

   // R7
   err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

endmodule

// File: tb/test_sg_chain_walker.sv
`timescale 1ns/1ps
module test_sg_chain_walker;

   localparam logic [31:0] BASE = 32'h80;
   localparam logic [31:0] DPTR = 32'h40;
   localparam int NV = 8;

   localparam logic [7:0]  V_CTL [NV] = '{8'h0D, 8'h05, 8'h05, 8'h05, 8'h0C, 8'h01, 8'h05, 8'h05};
   localparam logic [31:0] V_TOT [NV] = '{300, 500, 250, 250, 0, 0, 1000, 65535};
   localparam int          V_ND  [NV] = '{2, 2, 2, 2, 2, 2, 2, 1};
   localparam logic [15:0] V_L0  [NV] = '{100, 100, 100, 100, 100, 100, 100, 16'hFFFF};
   localparam logic [15:0] V_L1  [NV] = '{200, 200, 200, 200, 200, 200, 0, 0};
   localparam bit          V_DRN [NV] = '{0, 0, 0, 1, 0, 0, 0, 0};
   localparam logic [7:0]  V_RSP [NV] = '{8'h01, 8'hA1, 8'hC1, 8'h01, 8'h84, 8'h01, 8'h80, 8'h01};
   localparam int          V_SEG [NV] = '{2, 2, 2, 2, 0, 0, 1, 1};
   localparam bit          V_ERR [NV] = '{0, 1, 1, 0, 1, 0, 1, 0};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        eng_go, eng_reset, eng_halt;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_wstrb;
   logic        seg_valid, seg_ready;
   logic [31:0] seg_addr;
   logic [15:0] seg_len;
   logic [7:0]  seg_flags;
   logic        done, error, stopped, cmpl_evt;

   always #2 clk = ~clk;

   sg_chain_walker i_sg_chain_walker (
      .clk(clk), .rst_n(rst_n), .eng_go(eng_go), .eng_reset(eng_reset), .eng_halt(eng_halt),
      .cb_base(BASE), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
      .seg_flags(seg_flags), .done(done), .error(error), .stopped(stopped), .cmpl_evt(cmpl_evt)
   );

   logic [31:0] mem [64];
   logic [31:0] rd_log [64];
   logic [31:0] sg_addr_log [16];
   logic [7:0]  sg_flag_log [16];
   int rd_tot = 0, seg_tot = 0, wr_tot = 0, evt_tot = 0, cyc = 0;
   int wr_cyc = 0, done_cyc = 0;
   logic [31:0] last_wd = '0;
   logic [3:0]  last_ws = '0;
   logic        done_d = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      done_d <= done;
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr[7:2]];
         rd_log[rd_tot % 64] <= mem_addr;
         rd_tot <= rd_tot + 1;
      end
      if (mem_wr) begin
         wr_tot <= wr_tot + 1;
         last_wd <= mem_wdata;
         last_ws <= mem_wstrb;
         wr_cyc <= cyc;
      end
      if (seg_valid && seg_ready) begin
         sg_addr_log[seg_tot % 16] <= seg_addr;
         sg_flag_log[seg_tot % 16] <= seg_flags;
         seg_tot <= seg_tot + 1;
      end
      if (cmpl_evt) evt_tot <= evt_tot + 1;
      if (done && !done_d) done_cyc <= cyc;
   end

   int checks = 0, fails = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input int v);
      case (v)
         0: return "R6 exact";
         1: return "R7 short";
         2: return "R8 excess";
         3: return "R8 drain";
         4: return "R2 invalid";
         5: return "R3 nodata";
         6: return "R9 zero-len";
         default: return "R6 max-len";
      endcase
   endfunction

   task automatic load(input int v);
      for (int w = 0; w < 64; w++) mem[w] = '0;
      mem[BASE[7:2]]     = {V_CTL[v], 16'h0000, 8'h5A};
      mem[BASE[7:2] + 1] = V_TOT[v];
      mem[BASE[7:2] + 2] = DPTR;
      for (int i = 0; i < V_ND[v]; i++) begin
         logic [7:0] fl;
         fl = 8'h10;
         if (i == V_ND[v] - 1) fl = fl | 8'h80 | (V_DRN[v] ? 8'h02 : 8'h00);
         mem[DPTR[7:2] + 2*i]     = 32'h1000 * (i + 1);
         mem[DPTR[7:2] + 2*i + 1] = {fl, 8'h00, (i == 0) ? V_L0[v] : V_L1[v]};
      end
   endtask

   task automatic start();
      @(negedge clk); eng_go = 1'b1;
      @(negedge clk); eng_go = 1'b0;
   endtask

   task automatic wait_end();
      for (int n = 0; n < 2000 && !(done || stopped); n++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_seg();
      for (int n = 0; n < 2000 && !seg_valid; n++) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R13 watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int rd0, sg0, wr0, ev0;
      logic [31:0] a;
      logic [15:0] l;
      rst_n = 1'b0; eng_go = 1'b0; eng_reset = 1'b0; eng_halt = 1'b0; seg_ready = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 reset done", done, 0);
      chk("R13 reset error", error, 0);
      chk("R13 reset stopped", stopped, 0);
      chk("R13 reset seg_valid", seg_valid, 0);
      chk("R13 reset mem_rd", mem_rd, 0);

      // table of vectors
      for (int v = 0; v < NV; v++) begin
         load(v);
         rd0 = rd_tot; sg0 = seg_tot; wr0 = wr_tot; ev0 = evt_tot;
         start();
         wait_end();
         chk({tag_of(v), " response"}, last_wd[7:0], V_RSP[v]);
         chk({tag_of(v), " segments"}, seg_tot - sg0, V_SEG[v]);
         chk({tag_of(v), " error"}, error, V_ERR[v]);
         chk("R10 done", done, 1);
         chk("R10 one write", wr_tot - wr0, 1);
         chk("R10 strobe", last_ws, 4'b0001);
         chk("R10 done after write", done_cyc, wr_cyc + 1);
         chk("R11 event", evt_tot - ev0, V_CTL[v][3]);
         chk("R1 header addr0", rd_log[rd0 % 64], BASE);
         if (v == 0) begin
            chk("R1 header addr1", rd_log[(rd0 + 1) % 64], BASE + 4);
            chk("R1 header addr2", rd_log[(rd0 + 2) % 64], BASE + 8);
            chk("R5 desc0 addr", rd_log[(rd0 + 3) % 64], DPTR);
            chk("R5 desc1 addr", rd_log[(rd0 + 5) % 64], DPTR + 8);
            chk("R4 seg1 addr", sg_addr_log[(sg0 + 1) % 16], 32'h2000);
            chk("R5 seg1 end flag", sg_flag_log[(sg0 + 1) % 16], 8'h90);
            chk("R5 reads total", rd_tot - rd0, 7);
         end
         if (v == 4) chk("R2 reads total", rd_tot - rd0, 1);
         if (v == 5) chk("R3 reads total", rd_tot - rd0, 3);
      end

      // R4: stalled segment is held
      load(0);
      seg_ready = 1'b0;
      sg0 = seg_tot;
      start();
      wait_seg();
      a = seg_addr; l = seg_len;
      repeat (5) @(negedge clk);
      chk("R4 stall valid", seg_valid, 1);
      chk("R4 stall addr", seg_addr, a);
      chk("R4 stall len", seg_len, l);
      chk("R4 stall no accept", seg_tot - sg0, 0);
      seg_ready = 1'b1;
      wait_end();
      chk("R4 stall response", last_wd[7:0], 8'h01);

      // R12: halt mid walk
      load(1);
      seg_ready = 1'b0;
      wr0 = wr_tot;
      start();
      wait_seg();
      eng_halt = 1'b1;
      @(negedge clk); eng_halt = 1'b0;
      chk("R12 stopped", stopped, 1);
      chk("R12 done low", done, 0);
      chk("R12 seg dropped", seg_valid, 0);
      seg_ready = 1'b1;
      repeat (4) @(negedge clk);
      chk("R12 no write", wr_tot - wr0, 0);
      eng_reset = 1'b1;
      @(negedge clk); eng_reset = 1'b0;
      chk("R13 stopped cleared", stopped, 0);

      // R13: reset after an erroneous completion
      load(1);
      start();
      wait_end();
      chk("R13 pre error", error, 1);
      eng_reset = 1'b1;
      @(negedge clk); eng_reset = 1'b0;
      chk("R13 done cleared", done, 0);
      chk("R13 error cleared", error, 0);

      // R13: reset mid walk
      load(0);
      seg_ready = 1'b0;
      wr0 = wr_tot;
      start();
      wait_seg();
      eng_reset = 1'b1;
      @(negedge clk); eng_reset = 1'b0;
      chk("R13 mid seg dropped", seg_valid, 0);
      seg_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk("R13 mid no write", wr_tot - wr0, 0);
      chk("R13 mid idle", mem_rd, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule